// File: doc/BRIEF.md
# Dual-Rate Replicated Multiport RAM

This block is a memory wrapper that gives logic on a core clock four read ports and two write ports in every core cycle. It holds two identical copies of a true-dual-port array. Both copies are clocked by a fast clock at exactly twice the core rate, with its rising edges aligned to the core rising edges. Each write port writes both copies, so the copies always hold the same contents. Each copy serves two of the four read ports.

Each core cycle covers two fast edges. The first fast edge after a core edge is the write slot: both copies take both write requests. The fast edge that lines up with the next core edge is the read slot: each copy reads two addresses and registers the results. A read therefore sees any write made in the same core cycle. Read data appears one core cycle after the address is presented and stays steady for that whole cycle. The typical user is a hashing or state-machine datapath that must read three or four cells and write two cells in each cycle, with one read port to spare for delayed control data.

The first core cycle after reset is released performs no access. Two writes to the same cell in one cycle are reported on a registered flag.

Top module: `dualrate_mport_ram`

## Requirements
- R1: While reset is high, all four read data outputs and the clash flag are zero.
- R2: A word written through either write port is returned by every one of the four read ports, because both copies hold the same contents.
- R3: The four read ports are independent: four different addresses presented in one cycle each return their own cell's contents.
- R4: A read of an address written in the same core cycle returns the newly written data.
- R5: Read data for an address presented in core cycle N is valid from the core edge that ends cycle N. It holds through the whole of cycle N+1, including across the mid-cycle fast edge.
- R6: Two writes to different addresses in the same cycle are both stored.
- R7: When both write enables are high with equal addresses, the clash flag is 1 in the next cycle, and the cell keeps the data from write port 1 (port 1 has priority).
- R8: A write port whose enable is low leaves memory unchanged, whatever its address and data inputs hold.
- R9: The clash flag is 0 in the cycle after any cycle without both enables high on a shared address, including the case of equal addresses with only one enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| fclk | input | 1 | Fast clock, twice the core rate, rising edges aligned with clk |
| rst | input | 1 | Synchronous active-high reset, core domain |
| wr_en | input | 2 | Write enable per write port |
| wr_addr | input | 2×AW | Write address per write port |
| wr_data | input | 2×DW | Write data per write port |
| rd_addr | input | 4×AW | Read address per read port |
| rd_data | output | 4×DW | Read data per read port, one core cycle after the address |
| wr_clash | output | 1 | High in the cycle after two enabled writes hit the same address |

## Verification
The checks on data take three things for granted: fclk is exactly twice clk and in phase with it, the inputs change only away from clock edges, and no access is made in the first cycle after reset. The bench builds both clocks from one generator and drives the inputs 2 ns after each core edge. The check that the copies agree also assumes that a cell has been written before it is read on two ports at once. For this reason the bench keeps the idle read addresses distinct and fills the whole array before any read.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    // Physical organisation: replicated copies, each true dual-port.
    localparam int COPIES         = 2;
    localparam int PORTS_PER_COPY = 2;
    localparam int RD_PORTS       = COPIES * PORTS_PER_COPY;
    localparam int WR_PORTS       = PORTS_PER_COPY;

    // Role of a fast-clock edge inside one core cycle.
    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } fast_phase_e;

    // True when both write ports are enabled on the same cell.
    function automatic logic pair_clash(logic [WR_PORTS-1:0] en, logic same_addr);
        return (&en) && same_addr;
    endfunction
endpackage

// File: rtl/dmr_phase_track.sv
module dmr_phase_track
    import dmr_pkg::*;
(
    input  logic        clk,
    input  logic        fclk,
    input  logic        rst,
    output fast_phase_e phase
);
    // Core-domain toggle; the fast domain compares it with its last sample.
    logic core_tog;
    logic tog_seen;

    always_ff @(posedge clk) begin
        if (rst) core_tog <= 1'b0;
        else     core_tog <= ~core_tog;
    end

    always_ff @(posedge fclk) begin
        if (rst) tog_seen <= 1'b0;
        else     tog_seen <= core_tog;
    end

    // A changed toggle means a core edge has passed since the last fast
    // edge: the coming fast edge is the mid-cycle write slot.
    assign phase = (core_tog != tog_seen) ? PH_WRITE : PH_READ;
endmodule

// File: rtl/dmr_tdp_bank.sv
module dmr_tdp_bank
    import dmr_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic                             fclk,
    input  logic                             rst,
    input  logic [PORTS_PER_COPY-1:0]          we,
    input  logic [PORTS_PER_COPY-1:0]          re,
    input  logic [PORTS_PER_COPY-1:0][AW-1:0]  addr,
    input  logic [PORTS_PER_COPY-1:0][DW-1:0]  wdata,
    output logic [PORTS_PER_COPY-1:0][DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Ascending port order: the higher port's write lands last and wins.
    always_ff @(posedge fclk) begin
        for (int p = 0; p < PORTS_PER_COPY; p++) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    // Output registers load only when a read is requested, so they hold
    // across the other slot.
    always_ff @(posedge fclk) begin
        for (int p = 0; p < PORTS_PER_COPY; p++) begin
            if (rst)        rdata[p] <= '0;
            else if (re[p]) rdata[p] <= mem[addr[p]];
        end
    end
endmodule

// File: rtl/dmr_clash_flag.sv
module dmr_clash_flag
    import dmr_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WR_PORTS-1:0]         wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0] wr_addr,
    output logic                        flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= pair_clash(wr_en, wr_addr[0] == wr_addr[1]);
    end
endmodule

// File: rtl/dualrate_mport_ram.sv
module dualrate_mport_ram
    import dmr_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic                        clk,
    input  logic                        fclk,
    input  logic                        rst,
    input  logic [WR_PORTS-1:0]         wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0] wr_addr,
    input  logic [WR_PORTS-1:0][DW-1:0] wr_data,
    input  logic [RD_PORTS-1:0][AW-1:0] rd_addr,
    output logic [RD_PORTS-1:0][DW-1:0] rd_data,
    output logic                        wr_clash
);
    fast_phase_e phase;

    dmr_phase_track u_phase (
        .clk   (clk),
        .fclk  (fclk),
        .rst   (rst),
        .phase (phase)
    );

    dmr_clash_flag #(.AW(AW)) u_clash (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .flag    (wr_clash)
    );

    logic [PORTS_PER_COPY-1:0][DW-1:0] bank_q [COPIES];

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        logic [PORTS_PER_COPY-1:0]         b_we;
        logic [PORTS_PER_COPY-1:0]         b_re;
        logic [PORTS_PER_COPY-1:0][AW-1:0] b_addr;
        logic [PORTS_PER_COPY-1:0][DW-1:0] b_q;

        // Every copy sees every write port (mirroring); in the read slot
        // its ports serve this copy's share of the read ports.
        always_comb begin
            for (int p = 0; p < PORTS_PER_COPY; p++) begin
                b_we[p]   = (phase == PH_WRITE) && wr_en[p];
                b_re[p]   = (phase == PH_READ);
                b_addr[p] = (phase == PH_WRITE) ? wr_addr[p]
                                                : rd_addr[c*PORTS_PER_COPY + p];
            end
        end

        dmr_tdp_bank #(.AW(AW), .DW(DW)) u_bank (
            .fclk  (fclk),
            .rst   (rst),
            .we    (b_we),
            .re    (b_re),
            .addr  (b_addr),
            .wdata (wr_data),
            .rdata (b_q)
        );

        assign bank_q[c] = b_q;
    end

    always_comb begin
        for (int c = 0; c < COPIES; c++) begin
            for (int p = 0; p < PORTS_PER_COPY; p++) begin
                rd_data[c*PORTS_PER_COPY + p] = bank_q[c][p];
            end
        end
    end
endmodule

// File: rtl/dualrate_mport_ram_chk.sv
module dualrate_mport_ram_chk
    import dmr_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic                        clk,
    input  logic                        fclk,
    input  logic                        rst,
    input  logic [WR_PORTS-1:0]         wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0] wr_addr,
    input  logic [WR_PORTS-1:0][DW-1:0] wr_data,
    input  logic [RD_PORTS-1:0][AW-1:0] rd_addr,
    input  logic [RD_PORTS-1:0][DW-1:0] rd_data,
    input  logic                        wr_clash
);
    // No access is taken in the first cycle after reset release.
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic same_wr;
    assign same_wr = (wr_addr[0] == wr_addr[1]);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (wr_clash == 1'b0));

    p_clash_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en == 2'b11 && same_wr) |=> wr_clash);

    p_flag_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en == 2'b11 && same_wr) |=> !wr_clash);

    p_same_cycle_read_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_en[0] && !(wr_en[1] && same_wr) && rd_addr[0] == wr_addr[0])
        |=> (rd_data[0] == $past(wr_data[0])));

    p_port1_priority_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_en[1] && rd_addr[2] == wr_addr[1])
        |=> (rd_data[2] == $past(wr_data[1])));

    p_copies_agree_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && rd_addr[1] == rd_addr[3])
        |=> (rd_data[1] == rd_data[3]));
endmodule

bind dualrate_mport_ram dualrate_mport_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .fclk     (fclk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_clash (wr_clash)
);

// File: tb/dualrate_mport_ram_test.sv
module dualrate_mport_ram_test;
    localparam int AW    = 5;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;

    logic                 clk  = 1'b0;
    logic                 fclk = 1'b0;
    logic                 rst;
    logic [1:0]           wr_en;
    logic [1:0][AW-1:0]   wr_addr;
    logic [1:0][DW-1:0]   wr_data;
    logic [3:0][AW-1:0]   rd_addr;
    logic [3:0][DW-1:0]   rd_data;
    logic                 wr_clash;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];

    dualrate_mport_ram #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .fclk(fclk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_clash(wr_clash)
    );

    // 50 MHz core clock with a 100 MHz fast clock, rising edges aligned.
    initial begin
        forever begin
            #5 fclk = 1'b1; clk = ~clk;
            #5 fclk = 1'b0;
        end
    end

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'((a + 1) * 32'h9E3779B1) ^ DW'(salt * 32'h01000193);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        wr_en   = 2'b00;
        wr_addr = '0;
        wr_data = '0;
        for (int p = 0; p < 4; p++) rd_addr[p] = AW'(p);
    endtask

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(int a);
        for (int p = 0; p < 4; p++) rd_addr[p] = AW'(a);
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) check("R1 rd_data in reset", rd_data[p], '0);
        check("R1 wr_clash in reset", DW'(wr_clash), '0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEPTH; a += 2) begin
            wr_en = 2'b11;
            wr_addr[0] = AW'(a);     wr_data[0] = pat(a, 1);
            wr_addr[1] = AW'(a + 1); wr_data[1] = pat(a + 1, 1);
            model[a] = pat(a, 1);
            model[a + 1] = pat(a + 1, 1);
            step();
        end
        idle();
    endtask

    task automatic t_coherent();
        for (int a = 0; a < DEPTH; a++) begin
            read_all(a);
            step();
            for (int p = 0; p < 4; p++) check("R2 all read ports agree", rd_data[p], model[a]);
        end
        idle();
    endtask

    task automatic t_distinct();
        rd_addr[0] = 5'd7; rd_addr[1] = 5'd19; rd_addr[2] = 5'd30; rd_addr[3] = 5'd2;
        step();
        check("R3 port0", rd_data[0], model[7]);
        check("R3 port1", rd_data[1], model[19]);
        check("R3 port2", rd_data[2], model[30]);
        check("R3 port3", rd_data[3], model[2]);
        idle();
    endtask

    task automatic t_same_cycle();
        wr_en = 2'b01; wr_addr[0] = 5'd12; wr_data[0] = pat(12, 7);
        model[12] = pat(12, 7);
        read_all(12);
        step();
        idle();
        for (int p = 0; p < 4; p++) check("R4 read sees same-cycle write", rd_data[p], model[12]);
    endtask

    task automatic t_latency();
        read_all(3);
        step();
        check("R5 data after one cycle", rd_data[0], model[3]);
        read_all(4);
        #10;
        check("R5 held past mid-cycle edge", rd_data[0], model[3]);
        check("R5 held past mid-cycle edge p3", rd_data[3], model[3]);
        step();
        check("R5 next address next cycle", rd_data[0], model[4]);
        idle();
    endtask

    task automatic t_dual();
        wr_en = 2'b11;
        wr_addr[0] = 5'd20; wr_data[0] = pat(20, 9);
        wr_addr[1] = 5'd21; wr_data[1] = pat(21, 9);
        model[20] = pat(20, 9); model[21] = pat(21, 9);
        step();
        idle();
        check("R6 no clash on distinct", DW'(wr_clash), '0);
        rd_addr[0] = 5'd20; rd_addr[1] = 5'd20; rd_addr[2] = 5'd21; rd_addr[3] = 5'd21;
        step();
        check("R6 port0 write", rd_data[0], model[20]);
        check("R6 port1 write", rd_data[3], model[21]);
        idle();
    endtask

    task automatic t_disabled();
        wr_en = 2'b00;
        wr_addr[0] = 5'd8; wr_data[0] = 32'hDEAD_BEEF;
        wr_addr[1] = 5'd8; wr_data[1] = 32'hBAD0_BAD0;
        step();
        idle();
        read_all(8);
        step();
        for (int p = 0; p < 4; p++) check("R8 disabled write ignored", rd_data[p], model[8]);
        idle();
    endtask

    task automatic t_clash();
        wr_en = 2'b11;
        wr_addr[0] = 5'd9; wr_data[0] = 32'h1111_0000;
        wr_addr[1] = 5'd9; wr_data[1] = 32'h2222_0000;
        model[9] = 32'h2222_0000;
        step();
        idle();
        check("R7 clash flagged", DW'(wr_clash), DW'(1));
        read_all(9);
        step();
        for (int p = 0; p < 4; p++) check("R7 port1 wins", rd_data[p], model[9]);
        check("R9 flag clears", DW'(wr_clash), '0);
        idle();
    endtask

    task automatic t_one_enabled();
        wr_en = 2'b01;
        wr_addr[0] = 5'd10; wr_data[0] = 32'h3333_0001;
        wr_addr[1] = 5'd10; wr_data[1] = 32'h4444_0002;
        model[10] = 32'h3333_0001;
        step();
        idle();
        check("R9 no flag with one enable", DW'(wr_clash), '0);
        read_all(10);
        step();
        check("R9 enabled port data kept", rd_data[1], model[10]);
        idle();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (4) step();
        t_reset();
        rst = 1'b0;
        step();
        t_fill();
        t_coherent();
        t_distinct();
        t_same_cycle();
        t_latency();
        t_dual();
        t_disabled();
        t_clash();
        t_one_enabled();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule